// File: doc/BRIEF.md
# Interrupt Source Aggregator with Set/Clear Enable Mask

This block gathers five interrupt events into one active-low request line. Four of the events come in as one-cycle strobes from neighbouring logic: timer A underflow, timer B underflow, the time-of-day alarm, and the end of a shift-register transfer. The fifth event is a falling edge on an asynchronous, active-low flag pin. The block synchronizes that pin and detects the edge itself.

Each event sets its own sticky status bit, whether or not the source is enabled. An enable mask decides which status bits may pull the request line low.

Software changes the mask with a single write that carries a direction bit. With the direction bit set, the selected sources are turned on. With it clear, the selected sources are turned off. Sources that are not selected keep their enable.

The read port always shows the status word, with a summary request bit in the top position. A read strobe clears all latched status bits at the next clock edge, which releases the request line. An event that arrives in the same cycle as the read strobe survives the clear.

Top module: `intr_ctrl_reg`

## Requirements
- R1: After synchronous reset, all status bits and all enables are zero, `rd_data` reads 0x00 and `irq_n` is 1.
- R2: A one-cycle strobe sets a status bit at the next clock edge. `tmr_a_uf` sets bit 0, `tmr_b_uf` sets bit 1, `tod_alarm` sets bit 2 and `sr_done` sets bit 3.
- R3: A high-to-low transition on `flag_n` sets status bit 4 exactly once. Holding the pin low does not set it again, and a low-to-high transition does not set it.
- R4: Bits 6 and 5 of `rd_data` always read 0.
- R5: A status bit latches its event even when the source is disabled. In that case `irq_n` stays 1 and `rd_data` bit 7 reads 0.
- R6: A write with `wr_data[7]`=1 enables every source whose bit in `wr_data[4:0]` is 1. The other enables keep their value.
- R7: A write with `wr_data[7]`=0 disables every source whose bit in `wr_data[4:0]` is 1. The other enables keep their value.
- R8: `irq_n` is 0, and `rd_data` bit 7 is 1, exactly when some status bit is set and its source is enabled. A source becomes able to pull `irq_n` low from the edge that captures the enabling write.
- R9: A cycle with `rd_en`=1 clears every status bit at the next edge, which returns `irq_n` to 1.
- R10: A source event in the same cycle as `rd_en` is kept: its status bit is 1 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tmr_a_uf | input | 1 | Timer A underflow strobe |
| tmr_b_uf | input | 1 | Timer B underflow strobe |
| tod_alarm | input | 1 | Time-of-day alarm strobe |
| sr_done | input | 1 | Shift register transfer done strobe |
| flag_n | input | 1 | Asynchronous active-low flag pin |
| wr_en | input | 1 | Mask write strobe |
| wr_data | input | 8 | Bit 7 is the set/clear direction; bits 4:0 select sources |
| rd_en | input | 1 | Read strobe; clears status at the next edge |
| rd_data | output | 8 | Bit 7 is the request; bits 6:5 are 0; bits 4:0 are status |
| irq_n | output | 1 | Combined interrupt request, active low |

## Verification
The stimulus table runs events that arrive before their enable, events that arrive after their enable, and a read that coincides with a new event. Together these separate latch-always status from gated status, and a full clear from a clear that keeps concurrent events. The mask writes pair a set with the direction bit against the same pattern without it, and include a write that selects no source. That shows whether unselected enables hold their value and whether the direction bit really picks between set and clear. On the flag pin the test applies one falling edge, then a long low level, then a rising edge. Only the first of these may raise bit 4, which tells an edge detector apart from a level detector.

// File: rtl/icr_pkg.sv
package icr_pkg;
    localparam int N_SRC      = 5;
    localparam int REQ_BIT    = 7;
    localparam int DATA_W     = 8;

    typedef enum int {
        SRC_TMR_A = 0,
        SRC_TMR_B = 1,
        SRC_TOD   = 2,
        SRC_SR    = 3,
        SRC_FLAG  = 4
    } src_idx_e;

    typedef logic [N_SRC-1:0] src_vec_t;

    typedef struct packed {
        logic     set_mode;
        src_vec_t select;
    } mask_cmd_t;

    function automatic logic [DATA_W-1:0] read_word(input logic req, input src_vec_t st);
        logic [DATA_W-1:0] w;
        w = '0;
        w[N_SRC-1:0] = st;
        w[REQ_BIT]   = req;
        return w;
    endfunction
endpackage

// File: rtl/icr_flag_edge.sv
module icr_flag_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    output logic fall
);
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-1:0], pin_n};
    end

    assign fall = chain[STAGES] & ~chain[STAGES-1];

    p_single_fall_r3: assert property (@(posedge clk) disable iff (rst)
        fall |=> !fall);
endmodule

// File: rtl/icr_status.sv
module icr_status
    import icr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  src_vec_t events,
    input  logic     clr,
    output src_vec_t status
);
    always_ff @(posedge clk) begin
        if (rst)      status <= '0;
        else if (clr) status <= events;
        else          status <= status | events;
    end

    p_clear_on_read_r9: assert property (@(posedge clk) disable iff (rst)
        (clr && events == '0) |=> status == '0);
    p_keep_event_r10: assert property (@(posedge clk) disable iff (rst)
        (events != '0) |=> (status & $past(events)) == $past(events));
    p_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        (!clr && events == '0) |=> $stable(status));
endmodule

// File: rtl/icr_mask.sv
module icr_mask
    import icr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr,
    input  mask_cmd_t cmd,
    output src_vec_t  enables
);
    always_ff @(posedge clk) begin
        if (rst)
            enables <= '0;
        else if (wr) begin
            if (cmd.set_mode) enables <= enables | cmd.select;
            else              enables <= enables & ~cmd.select;
        end
    end

    p_set_bits_r6: assert property (@(posedge clk) disable iff (rst)
        (wr && cmd.set_mode) |=> (enables & $past(cmd.select)) == $past(cmd.select));
    p_clear_bits_r7: assert property (@(posedge clk) disable iff (rst)
        (wr && !cmd.set_mode) |=> (enables & $past(cmd.select)) == '0);
    p_others_kept_r6: assert property (@(posedge clk) disable iff (rst)
        wr |=> (enables & ~$past(cmd.select)) == ($past(enables) & ~$past(cmd.select)));
    p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable(enables));
endmodule

// File: rtl/intr_ctrl_reg.sv
module intr_ctrl_reg
    import icr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tmr_a_uf,
    input  logic              tmr_b_uf,
    input  logic              tod_alarm,
    input  logic              sr_done,
    input  logic              flag_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq_n
);
    logic      flag_fall;
    src_vec_t  events;
    src_vec_t  status;
    src_vec_t  enables;
    mask_cmd_t cmd;
    logic      req;
    logic      unused_wr_bits;

    icr_flag_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk   (clk),
        .rst   (rst),
        .pin_n (flag_n),
        .fall  (flag_fall)
    );

    always_comb begin
        events            = '0;
        events[SRC_TMR_A] = tmr_a_uf;
        events[SRC_TMR_B] = tmr_b_uf;
        events[SRC_TOD]   = tod_alarm;
        events[SRC_SR]    = sr_done;
        events[SRC_FLAG]  = flag_fall;
    end

    assign cmd.set_mode   = wr_data[REQ_BIT];
    assign cmd.select     = wr_data[N_SRC-1:0];
    assign unused_wr_bits = ^wr_data[REQ_BIT-1:N_SRC];

    icr_status u_status (
        .clk    (clk),
        .rst    (rst),
        .events (events),
        .clr    (rd_en),
        .status (status)
    );

    icr_mask u_mask (
        .clk     (clk),
        .rst     (rst),
        .wr      (wr_en),
        .cmd     (cmd),
        .enables (enables)
    );

    assign req     = |(status & enables);
    assign irq_n   = ~req;
    assign rd_data = read_word(req, status);

    p_unused_zero_r4: assert property (@(posedge clk) disable iff (rst)
        rd_data[6:5] == 2'b00);
    p_req_needs_enable_r8: assert property (@(posedge clk) disable iff (rst)
        !irq_n |-> (status != '0 && enables != '0));
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (irq_n && rd_data == '0));
endmodule

// File: tb/intr_ctrl_reg_test.sv
module intr_ctrl_reg_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tmr_a_uf = 1'b0, tmr_b_uf = 1'b0, tod_alarm = 1'b0, sr_done = 1'b0;
    logic       flag_n = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       irq_n;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    intr_ctrl_reg uut (
        .clk(clk), .rst(rst), .tmr_a_uf(tmr_a_uf), .tmr_b_uf(tmr_b_uf),
        .tod_alarm(tod_alarm), .sr_done(sr_done), .flag_n(flag_n),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_data), .irq_n(irq_n)
    );

    // {ev[3:0] (bit0 timer A .. bit3 shift), wr, wdata, rd, exp_rd, exp_irq_n after edge}
    localparam logic [22:0] VEC [15] = '{
        {4'b0001, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1}, // R2 R5 A latched, disabled
        {4'b0000, 1'b0, 8'h00, 1'b1, 8'h01, 1'b1}, // R5 read shows A, no req
        {4'b0000, 1'b1, 8'h83, 1'b0, 8'h00, 1'b1}, // R6 enable A,B
        {4'b0010, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0}, // R2 R8 B fires
        {4'b0000, 1'b0, 8'h00, 1'b1, 8'h82, 1'b1}, // R8 R9 read + release
        {4'b0100, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1}, // R2 R5 tod, disabled
        {4'b0000, 1'b1, 8'h84, 1'b0, 8'h00, 1'b0}, // R6 R8 enable after latch
        {4'b0000, 1'b1, 8'h01, 1'b0, 8'h00, 1'b0}, // R7 disable A only
        {4'b0000, 1'b1, 8'h04, 1'b0, 8'h00, 1'b1}, // R7 disable tod
        {4'b1000, 1'b0, 8'h00, 1'b1, 8'h04, 1'b1}, // R10 shift during read
        {4'b0000, 1'b1, 8'h88, 1'b0, 8'h00, 1'b0}, // R6 R10 shift kept
        {4'b0000, 1'b0, 8'h00, 1'b1, 8'h88, 1'b1}, // R9
        {4'b0001, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1}, // R7 A still disabled
        {4'b0000, 1'b1, 8'h80, 1'b0, 8'h00, 1'b1}, // R6 empty select no change
        {4'b0000, 1'b0, 8'h00, 1'b1, 8'h01, 1'b1}  // R9
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic step(input logic [3:0] ev, input logic wr, input logic [7:0] wd,
                        input logic rd, input logic [7:0] exp_rd, input logic exp_irqn,
                        input string req);
        {sr_done, tod_alarm, tmr_b_uf, tmr_a_uf} = ev;
        wr_en = wr; wr_data = wd; rd_en = rd;
        #1;
        if (rd) check(req, rd_data, exp_rd);
        @(negedge clk);
        {sr_done, tod_alarm, tmr_b_uf, tmr_a_uf} = 4'b0;
        wr_en = 1'b0; wr_data = 8'h00; rd_en = 1'b0;
        check(req, {7'b0, irq_n}, {7'b0, exp_irqn});
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1", rd_data, 8'h00);
        check("R1", {7'b0, irq_n}, 8'h01);

        for (int i = 0; i < 15; i++)
            step(VEC[i][22:19], VEC[i][18], VEC[i][17:10], VEC[i][9], VEC[i][8:1], VEC[i][0],
                 $sformatf("R2-vec%0d", i));

        // R4: all enabled, all events, read shows bit 7 and zeros in 6:5
        step(4'b0000, 1'b1, 8'hFF, 1'b0, 8'h00, 1'b1, "R6");
        step(4'b1111, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, "R8");
        step(4'b0000, 1'b0, 8'h00, 1'b1, 8'h8F, 1'b1, "R4");

        // R3 flag pin: one falling edge sets bit 4
        flag_n = 1'b0;
        repeat (5) @(negedge clk);
        check("R3", {7'b0, irq_n}, 8'h00);
        step(4'b0000, 1'b0, 8'h00, 1'b1, 8'h90, 1'b1, "R3");
        repeat (6) @(negedge clk);
        check("R3 held low", {7'b0, irq_n}, 8'h01);
        flag_n = 1'b1;
        repeat (6) @(negedge clk);
        check("R3 rising", rd_data, 8'h00);

        // R1 reset mid-run clears status and enables
        step(4'b1111, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, "R8");
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1", rd_data, 8'h00);
        check("R1", {7'b0, irq_n}, 8'h01);
        step(4'b0001, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, "R1 enables cleared");

        finish_run();
    end
endmodule